// File: doc/BRIEF.md
# Sampling Delay Tap Calibration Engine

This engine picks the receive sampling delay for a serial-flash read path. After a start request it reads the attached device's 3-byte identifier once at the slow, always-safe clock rate and keeps that answer as the reference. It then switches to the full clock rate and walks a delay tap from zero upward. At each tap it issues one identifier read and compares the answer with the reference. The passing taps form a window, and the engine places the final tap inside that window.

The engine does not drive the flash pins and does not produce any clock. It talks to an external sequencer through a request/acknowledge pair that carries the read-ID command. It also drives a rate-select level, which the clock logic is expected to follow. At the end it presents a 16-bit delay control word, the chosen tap and a fallback flag. A one-cycle done pulse marks the end of each run.

When the requested rate is slow there is nothing to calibrate. In that case the engine clears the delay and finishes at once. If the reference read shows no device, calibration is skipped.

Top module: `dlycal_engine`

## Requirements
- R1: Every transaction request carries command 0x9F. The first transaction of a calibrating run is the reference read, and it is issued with `rate_fast` = 0 and `dly_ctrl` = 0.
- R2: The first identifier byte is `txn_id[23:16]` and the second is `txn_id[15:8]`. If these two bytes are both 0xFF, or both 0x00, the run ends after the reference read with `no_dev` = 1, `dly_ctrl` = 0, `fallback` = 0 and `rate_fast` = 1.
- R3: Sweep probes use taps 0, 10, 20 and so on, up to `MAX_TAP`. When the next step would exceed `MAX_TAP`, `MAX_TAP` itself is probed as the last point. Each probe is issued with `rate_fast` = 1. During a probe, `dly_ctrl` is 0 for tap 0; for any other tap it is bit 15 set with the tap in the low bits.
- R4: The first matching tap is the left edge. The sweep ends at the first mismatch that follows a match, and the right edge is the last matching tap.
- R5: A window is accepted only if right minus left is at least 80. Otherwise the run ends with `fallback` = 1, `dly_ctrl` = 0, `chosen_tap` = 0 and `rate_fast` = 0. The same failure result applies when no tap matches.
- R6: If the accepted window starts at tap 0 and ends below `MAX_TAP`, the chosen tap is left + floor((right − left)·2/5).
- R7: Any other accepted window gives the chosen tap left + floor((right − left)/2).
- R8: On success the engine sets `chosen_tap` to the chosen tap, `dly_ctrl` to bit 15 OR the chosen tap, `fallback` to 0 and `rate_fast` to 1.
- R9: If `rate_high` is 0 when start is taken, no transaction is issued. The delay is cleared and `done` rises on the cycle after start.
- R10: `done` is a single-cycle pulse, with `busy` low during it. The result outputs hold their values after `done` until the next start.
- R11: `txn_req` stays high until `txn_ack` is sampled high. While a request is pending, `dly_ctrl` and `rate_fast` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a calibration run (taken when idle) |
| rate_high | input | 1 | Requested rate is above the slow threshold |
| txn_req | output | 1 | Identifier read request to the sequencer |
| txn_cmd | output | 8 | Command for the request, always 0x9F |
| txn_ack | input | 1 | Read complete; `txn_id` valid this cycle |
| txn_id | input | 24 | Identifier bytes, first byte in bits 23:16 |
| rate_fast | output | 1 | 1 selects the full rate, 0 the slow rate |
| dly_ctrl | output | 16 | Delay control word: enable in bit 15, tap below |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| fallback | output | 1 | Calibration failed; slow rate requested |
| no_dev | output | 1 | Reference read found no device |
| chosen_tap | output | TAP_W | Final tap (TAP_W = clog2(MAX_TAP+1)) |

## Verification
The bench targets the sweep's end conditions. These are a window that runs up to the last tap, where a design that forgets the clamped final point stops at 510 and centres wrongly. Another is a window exactly 80 wide, where an off-by-one rejects it. A third is a second passing region after a gap, which a design that keeps sweeping would merge into one wide window. It also checks the 2/5 placement against the midpoint for windows starting at tap 0, including a window that covers every tap, which must use the midpoint. Identifier patterns with only one of the two leading bytes at 0xFF are included, so that a loose no-device test would wrongly skip calibration. Responder latencies of zero to three cycles expose any design that drops its request early or moves the delay while a read is pending.

// File: rtl/dlycal_pkg.sv
`timescale 1ns/1ps
// Shared types and constants for the sampling delay calibration engine.
// Assumes a 16-bit delay control word with its enable bit at the top.
package dlycal_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_REF   = 3'd1,
        ST_SET   = 3'd2,
        ST_PROBE = 3'd3,
        ST_EVAL  = 3'd4,
        ST_FIN   = 3'd5
    } cal_state_t;

    localparam int         DLY_W       = 16;
    localparam int         DLY_EN_BIT  = 15;
    localparam int         ID_W        = 24;
    localparam logic [7:0] READ_ID_CMD = 8'h9F;
endpackage

// File: rtl/dlycal_sweep.sv
`timescale 1ns/1ps
// Tap stepper: holds the tap under test and advances it by STEP, clamping the
// final point to MAX_TAP. Assumes clear and advance never coincide.
module dlycal_sweep #(
    parameter int MAX_TAP = 511,
    parameter int STEP    = 10,
    parameter int TAP_W   = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             advance,
    output logic [TAP_W-1:0] tap,
    output logic             at_last
);
    localparam logic [TAP_W:0] MAX_EXT  = (TAP_W+1)'(MAX_TAP);
    localparam logic [TAP_W:0] STEP_EXT = (TAP_W+1)'(STEP);

    logic [TAP_W:0] stepped;

    assign stepped = {1'b0, tap} + STEP_EXT;
    assign at_last = ({1'b0, tap} == MAX_EXT);

    // Tap register: zero on clear, step or clamp on advance.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            tap <= '0;
        end else if (advance && !at_last) begin
            tap <= (stepped > MAX_EXT) ? MAX_EXT[TAP_W-1:0] : stepped[TAP_W-1:0];
        end
    end

    // R3: tap never leaves the legal range.
    a_r3_tap_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, tap} <= MAX_EXT);

    // R3: each advance lands one step further or on the clamped last tap.
    a_r3_step_rule: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !at_last && !clear) |=>
        (({1'b0, tap} == {1'b0, $past(tap)} + STEP_EXT) || at_last));
endmodule

// File: rtl/dlycal_window.sv
`timescale 1ns/1ps
// Window edge tracker: records the first and the latest matching tap and flags
// a mismatch that follows a match. Assumes sample is high once per probe result.
module dlycal_window #(
    parameter int TAP_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             sample,
    input  logic             match,
    input  logic [TAP_W-1:0] tap,
    output logic [TAP_W-1:0] left,
    output logic [TAP_W-1:0] right,
    output logic             valid,
    output logic             miss_after_hit
);
    assign miss_after_hit = valid && !match;

    // Edge registers: left set once by the first match, right follows matches.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            left  <= '0;
            right <= '0;
            valid <= 1'b0;
        end else if (sample && match) begin
            right <= tap;
            valid <= 1'b1;
            if (!valid) begin
                left <= tap;
            end
        end
    end

    // R4: the window is never inverted.
    a_r4_edge_order: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (right >= left));

    // R4: once a match has been seen, the left edge is frozen until cleared.
    a_r4_left_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !clear) |=> $stable(left));
endmodule

// File: rtl/dlycal_pick.sv
`timescale 1ns/1ps
// Placement logic: accepts or rejects a window by width and places the tap,
// using 2/5 for windows anchored at tap 0 that end early, midpoint otherwise.
// Purely combinational; assumes edges are already final when read.
module dlycal_pick #(
    parameter int MAX_TAP    = 511,
    parameter int TAP_W      = 9,
    parameter int MIN_WINDOW = 80
) (
    input  logic [TAP_W-1:0] left,
    input  logic [TAP_W-1:0] right,
    input  logic             valid,
    output logic             ok,
    output logic [TAP_W-1:0] chosen
);
    localparam int SW = TAP_W + 2;

    logic [SW-1:0] span;
    logic [SW-1:0] early_pos;
    logic [SW-1:0] mid_pos;
    logic          use_early;

    // Width test and both placement candidates.
    always_comb begin
        span      = SW'(right) - SW'(left);
        ok        = valid && (span >= SW'(MIN_WINDOW));
        early_pos = SW'(left) + ((span << 1) / SW'(5));
        mid_pos   = SW'(left) + (span >> 1);
        use_early = (left == '0) && (SW'(right) < SW'(MAX_TAP));
        chosen    = '0;
        if (ok) begin
            chosen = use_early ? early_pos[TAP_W-1:0] : mid_pos[TAP_W-1:0];
        end
    end

    // R6/R7: an accepted placement lies inside the window.
    always_comb begin
        if (ok) begin
            a_r7_inside_window: assert (chosen >= left && chosen <= right);
        end
    end
endmodule

// File: rtl/dlycal_engine.sv
`timescale 1ns/1ps
// Sampling delay calibration engine top. Sequences a slow-rate reference ID
// read, a full-rate tap sweep through the transaction handshake, and the final
// delay write. Assumes the sequencer holds txn_id valid while txn_ack is high.
module dlycal_engine
    import dlycal_pkg::*;
#(
    parameter int MAX_TAP    = 511,
    parameter int TAP_STEP   = 10,
    parameter int MIN_WINDOW = 80,
    localparam int TAP_W     = $clog2(MAX_TAP + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             rate_high,
    output logic             txn_req,
    output logic [7:0]       txn_cmd,
    input  logic             txn_ack,
    input  logic [23:0]      txn_id,
    output logic             rate_fast,
    output logic [15:0]      dly_ctrl,
    output logic             busy,
    output logic             done,
    output logic             fallback,
    output logic             no_dev,
    output logic [TAP_W-1:0] chosen_tap
);
    cal_state_t       state;
    logic [ID_W-1:0]  ref_id;
    logic [TAP_W-1:0] tap;
    logic             at_last;
    logic [TAP_W-1:0] win_left;
    logic [TAP_W-1:0] win_right;
    logic             win_valid;
    logic             miss_after_hit;
    logic             pick_ok;
    logic [TAP_W-1:0] pick_tap;
    logic             take_start;
    logic             probe_done;
    logic             id_match;
    logic             id_absent;
    logic             sweep_stop;

    // Encodes a tap into the delay control word; zero tap disables the delay.
    function automatic logic [DLY_W-1:0] enc_tap(input logic [TAP_W-1:0] t);
        logic [DLY_W-1:0] w;
        w              = '0;
        w[TAP_W-1:0]   = t;
        w[DLY_EN_BIT]  = |t;
        return w;
    endfunction

    assign take_start = (state == ST_IDLE) && start;
    assign probe_done = (state == ST_PROBE) && txn_ack;
    assign id_match   = (txn_id == ref_id);
    assign id_absent  = (txn_id[23:16] == txn_id[15:8]) &&
                        ((txn_id[23:16] == 8'hFF) || (txn_id[23:16] == 8'h00));
    assign sweep_stop = miss_after_hit || at_last;

    assign txn_req = (state == ST_REF) || (state == ST_PROBE);
    assign txn_cmd = READ_ID_CMD;
    assign busy    = (state != ST_IDLE) && (state != ST_FIN);
    assign done    = (state == ST_FIN);

    dlycal_sweep #(
        .MAX_TAP (MAX_TAP),
        .STEP    (TAP_STEP),
        .TAP_W   (TAP_W)
    ) u_sweep (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (take_start),
        .advance (probe_done && !sweep_stop),
        .tap     (tap),
        .at_last (at_last)
    );

    dlycal_window #(
        .TAP_W (TAP_W)
    ) u_window (
        .clk            (clk),
        .rst_n          (rst_n),
        .clear          (take_start),
        .sample         (probe_done),
        .match          (id_match),
        .tap            (tap),
        .left           (win_left),
        .right          (win_right),
        .valid          (win_valid),
        .miss_after_hit (miss_after_hit)
    );

    dlycal_pick #(
        .MAX_TAP    (MAX_TAP),
        .TAP_W      (TAP_W),
        .MIN_WINDOW (MIN_WINDOW)
    ) u_pick (
        .left   (win_left),
        .right  (win_right),
        .valid  (win_valid),
        .ok     (pick_ok),
        .chosen (pick_tap)
    );

    // Run sequencer and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            ref_id     <= '0;
            rate_fast  <= 1'b0;
            dly_ctrl   <= '0;
            fallback   <= 1'b0;
            no_dev     <= 1'b0;
            chosen_tap <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        fallback   <= 1'b0;
                        no_dev     <= 1'b0;
                        chosen_tap <= '0;
                        dly_ctrl   <= '0;
                        rate_fast  <= 1'b0;
                        state      <= rate_high ? ST_REF : ST_FIN;
                    end
                end
                ST_REF: begin
                    if (txn_ack) begin
                        ref_id    <= txn_id;
                        rate_fast <= 1'b1;
                        if (id_absent) begin
                            no_dev <= 1'b1;
                            state  <= ST_FIN;
                        end else begin
                            state  <= ST_SET;
                        end
                    end
                end
                ST_SET: begin
                    dly_ctrl <= enc_tap(tap);
                    state    <= ST_PROBE;
                end
                ST_PROBE: begin
                    if (txn_ack) begin
                        state <= sweep_stop ? ST_EVAL : ST_SET;
                    end
                end
                ST_EVAL: begin
                    if (pick_ok) begin
                        chosen_tap <= pick_tap;
                        dly_ctrl   <= enc_tap(pick_tap);
                        fallback   <= 1'b0;
                        rate_fast  <= 1'b1;
                    end else begin
                        chosen_tap <= '0;
                        dly_ctrl   <= '0;
                        fallback   <= 1'b1;
                        rate_fast  <= 1'b0;
                    end
                    state <= ST_FIN;
                end
                ST_FIN: begin
                    state <= ST_IDLE;
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    // R11: a pending request is held until acknowledged.
    a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_req && !txn_ack) |=> txn_req);

    // R11: delay word and rate select do not move under a pending request.
    a_r11_cfg_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_req && !txn_ack) |=> ($stable(dly_ctrl) && $stable(rate_fast)));

    // R1: the reference read runs slow with the delay disabled.
    a_r1_ref_slow: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_req && !win_valid && (tap == '0) && !rate_fast) |-> (dly_ctrl == '0));

    // R10: done never lasts more than one cycle.
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5: a failed run leaves the delay disabled and the slow rate selected.
    a_r5_fail_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fallback) |-> ((dly_ctrl == '0) && !rate_fast && (chosen_tap == '0)));

    // R8: a successful run ends with the enable bit carrying the chosen tap.
    a_r8_ok_encoded: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fallback && (chosen_tap != '0)) |->
        (dly_ctrl[DLY_EN_BIT] && (dly_ctrl[TAP_W-1:0] == chosen_tap)));
endmodule

// File: tb/dlycal_engine_bench.sv
`timescale 1ns/1ps
// Self-checking bench: a behavioural flash responder with a configurable
// passing tap profile, and a behavioural reference of the expected sweep.
module dlycal_engine_bench;
    localparam int MAX_TAP = 511;
    localparam int TAP_W   = 9;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             rate_high = 1'b0;
    logic             txn_req;
    logic [7:0]       txn_cmd;
    logic             txn_ack = 1'b0;
    logic [23:0]      txn_id = '0;
    logic             rate_fast;
    logic [15:0]      dly_ctrl;
    logic             busy;
    logic             done;
    logic             fallback;
    logic             no_dev;
    logic [TAP_W-1:0] chosen_tap;

    int total = 0;
    int fails = 0;
    int cyc   = 0;

    logic [23:0] ref_word = '0;
    int lo1 = 1, hi1 = 0, lo2 = 1, hi2 = 0;
    int lat = 0;
    int wcnt = 0;
    int   rec_tap[$];
    int   rec_fast[$];
    int   rec_dly[$];

    always #2.5 clk = ~clk;

    dlycal_engine u_dlycal_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .rate_high  (rate_high),
        .txn_req    (txn_req),
        .txn_cmd    (txn_cmd),
        .txn_ack    (txn_ack),
        .txn_id     (txn_id),
        .rate_fast  (rate_fast),
        .dly_ctrl   (dly_ctrl),
        .busy       (busy),
        .done       (done),
        .fallback   (fallback),
        .no_dev     (no_dev),
        .chosen_tap (chosen_tap)
    );

    task automatic chk(input bit cond, input string what, input int act, input int exp);
        total++;
        if (!cond) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    function automatic bit in_win(input int t);
        return (t >= lo1 && t <= hi1) || (t >= lo2 && t <= hi2);
    endfunction

    // Responder: answers each request after lat cycles, passing taps echo the reference.
    always @(negedge clk) begin
        if (!rst_n) begin
            txn_ack = 1'b0;
            wcnt    = 0;
        end else if (txn_ack) begin
            txn_ack = 1'b0;
            wcnt    = 0;
        end else if (txn_req) begin
            if (wcnt >= lat) begin
                int t;
                t = dly_ctrl[15] ? int'(dly_ctrl[8:0]) : 0;
                rec_tap.push_back(t);
                rec_fast.push_back(int'(rate_fast));
                rec_dly.push_back(int'(dly_ctrl));
                if (!rate_fast || in_win(t)) txn_id = ref_word;
                else                         txn_id = ref_word ^ 24'h5A5A5A;
                txn_ack = 1'b1;
            end else begin
                wcnt++;
            end
        end
    end

    // Per-clock watch: command code on requests, done and busy exclusive.
    always @(negedge clk) begin
        if (rst_n) begin
            if (txn_req) chk(txn_cmd == 8'h9F, "R1 command code", txn_cmd, 8'h9F);
            if (done)    chk(!busy, "R10 busy low at done", busy, 0);
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            fails++;
            total++;
            $display("FAIL watchdog: actual %0d expected below %0d", cyc, 190000);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    task automatic run(input string tag, input bit hi_rate, input logic [23:0] refw,
                       input int a_lo, input int a_hi, input int b_lo, input int b_hi,
                       input int l);
        int  exp_taps[$];
        int  t, left, right, n;
        bit  valid, ok, absent, m;
        int  exp_chosen;
        ref_word = refw; lo1 = a_lo; hi1 = a_hi; lo2 = b_lo; hi2 = b_hi; lat = l;
        rec_tap.delete(); rec_fast.delete(); rec_dly.delete();
        absent = (refw[23:16] == refw[15:8]) && (refw[23:16] == 8'hFF || refw[23:16] == 8'h00);
        // Reference of the sweep from the requirements.
        valid = 0; left = 0; right = 0; t = 0;
        if (hi_rate && !absent) begin
            forever begin
                exp_taps.push_back(t);
                m = in_win(t);
                if (valid && !m) break;
                if (m) begin
                    if (!valid) left = t;
                    valid = 1; right = t;
                end
                if (t == MAX_TAP) break;
                t = (t + 10 > MAX_TAP) ? MAX_TAP : t + 10;
            end
        end
        ok = valid && (right - left >= 80);
        exp_chosen = !ok ? 0 : ((left == 0 && right < MAX_TAP) ? left + ((right - left) * 2) / 5
                                                               : left + (right - left) / 2);
        @(negedge clk); start = 1'b1; rate_high = hi_rate;
        @(negedge clk); start = 1'b0;
        n = 0;
        while (!done && n < 5000) begin @(negedge clk); n++; end
        chk(n < 5000, {tag, " R10 done seen"}, n, 0);
        if (!hi_rate) begin
            chk(n == 0, {tag, " R9 immediate done"}, n, 0);
            chk(rec_tap.size() == 0, {tag, " R9 no transaction"}, rec_tap.size(), 0);
            chk(dly_ctrl == 0 && !fallback && !no_dev && !rate_fast, {tag, " R9 cleared result"},
                dly_ctrl, 0);
        end else if (absent) begin
            chk(rec_tap.size() == 1, {tag, " R2 single read"}, rec_tap.size(), 1);
            chk(no_dev && !fallback && dly_ctrl == 0 && rate_fast, {tag, " R2 no-device result"},
                {no_dev, fallback, rate_fast}, 3'b101);
        end else begin
            chk(rec_tap.size() == exp_taps.size() + 1, {tag, " R3/R4 probe count"},
                rec_tap.size(), exp_taps.size() + 1);
            if (rec_tap.size() > 0)
                chk(rec_fast[0] == 0 && rec_dly[0] == 0, {tag, " R1 reference slow, no delay"},
                    rec_dly[0] + rec_fast[0], 0);
            for (int i = 0; i < exp_taps.size() && i + 1 < rec_tap.size(); i++) begin
                int ed;
                ed = (exp_taps[i] == 0) ? 0 : (32'h8000 | exp_taps[i]);
                if (rec_dly[i+1] != ed || rec_fast[i+1] != 1)
                    chk(0, {tag, " R3 probe delay word"}, rec_dly[i+1], ed);
            end
            chk(!no_dev, {tag, " R2 device present"}, no_dev, 0);
            chk(fallback == !ok, {tag, " R5 fallback"}, fallback, !ok);
            chk(chosen_tap == exp_chosen, {tag, " R6/R7 chosen tap"}, chosen_tap, exp_chosen);
            chk(dly_ctrl == (ok ? (16'h8000 | exp_chosen) : 0), {tag, " R8 delay word"},
                dly_ctrl, ok ? (32'h8000 | exp_chosen) : 0);
            chk(rate_fast == ok, {tag, " R5/R8 rate select"}, rate_fast, ok);
        end
        // R10: results held, no second done pulse.
        begin
            logic [15:0] hd; logic [TAP_W-1:0] hc;
            hd = dly_ctrl; hc = chosen_tap;
            repeat (4) @(negedge clk);
            chk(!done && !busy && dly_ctrl == hd && chosen_tap == hc, {tag, " R10 result held"},
                dly_ctrl, hd);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(!txn_req && !done && !busy && dly_ctrl == 0 && !fallback && !no_dev &&
            chosen_tap == 0 && !rate_fast, "R10 reset state", dly_ctrl, 0);
        rst_n = 1'b1;
        run("slow-rate",      1'b0, 24'hC84017, 0, 600, 1, 0, 0);
        run("no-dev-ff",      1'b1, 24'hFFFF12, 0, 600, 1, 0, 1);
        run("no-dev-00",      1'b1, 24'h0000AB, 0, 600, 1, 0, 0);
        run("anchored-2/5",   1'b1, 24'hFF0034, 0, 205, 1, 0, 1);
        run("mid-window",     1'b1, 24'hC22018, 95, 300, 1, 0, 0);
        run("to-last-tap",    1'b1, 24'h00EF40, 300, 600, 1, 0, 2);
        run("all-pass",       1'b1, 24'h20BA19, 0, 600, 1, 0, 3);
        run("narrow-70",      1'b1, 24'hEF4018, 100, 175, 1, 0, 1);
        run("exact-80",       1'b1, 24'h9D6017, 100, 185, 1, 0, 0);
        run("no-match",       1'b1, 24'h1C7016, 1000, 0, 1, 0, 2);
        run("split-windows",  1'b1, 24'hC22017, 20, 50, 100, 400, 1);
        run("anchored-again", 1'b1, 24'hFF0034, 0, 255, 1, 0, 0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule